// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits at the device side of a four-bank single-data-rate SDRAM. On every rising clock edge it samples the command pins: chip select, row strobe, column strobe, write enable, clock enable, bank select and the address bus. It turns them into one decoded operation: activate, read, write, single-bank precharge, all-bank precharge, mode register load, burst stop, auto refresh or self refresh. A deselect or a no-operation produces no strobe.

It holds a state for each bank: idle, active, or closing after an auto-precharge access. It also records the row opened in each active bank. A legal command is reported for one cycle on a registered strobe, together with its bank, row and column. A command that the current bank state does not allow raises a one-cycle error flag instead and leaves every bank untouched. The burst-length field of the stored mode word sets how long an auto-precharge access keeps its bank closing.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready interface and no back-pressure. Results appear on the outputs one clock after the edge that sampled the command.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset every bank is idle (`bank_open` = 0), `cmd_valid` and `illegal` are low, and `mode_op` is 0.
- R2: When `cs_n` is sampled high, the command is masked: no strobe, no error flag, and no bank state changes.
- R3: With `cke` high at the previous edge, the pins {cs_n,ras_n,cas_n,we_n} decode as follows. 0011 is activate (op 1). 0101 is read (op 2). 0100 is write (op 3). 0010 is precharge. 0000 is mode load (op 6). 0110 is burst stop (op 7). 0001 is refresh. 0111 is a no-operation and produces no strobe. The result is registered and shown for one cycle after the sampling edge.
- R4: Activate is legal only for an idle bank. It opens bank `ba` and records `addr[12:0]` as its row. A later read or write to that bank reports the recorded row on `cmd_row`.
- R5: Read and write are legal only for a bank in the active state. They report `cmd_col` = `addr[8:0]`, `cmd_ap` = `addr[10]` and `cmd_bank` = `ba`.
- R6: Precharge with `addr[10]` low (op 4) closes bank `ba` only. With `addr[10]` high (op 5) it closes every bank, including one that is closing.
- R7: Mode load is legal only while all banks are idle. It stores `addr[12:0]` into `mode_op`.
- R8: A command that is illegal for the current state sets `illegal` for one cycle, keeps `cmd_valid` low, and changes no bank state and no mode word.
- R9: A read or write with auto precharge puts its bank into the closing state. The bank counts as open, and activate, read and write to it are illegal. It becomes idle after BL enabled clock edges following the command. BL comes from `mode_op[2:0]`: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and any other value gives 512.
- R10: A command is decoded only if `cke` was high at the previous edge; otherwise it is ignored. While `cke` was low at the previous edge, the auto-precharge countdown is frozen.
- R11: Refresh is legal only while all banks are idle. It reports op 8 when `cke` is high in the sampling cycle and op 9 (self refresh) when `cke` is low. Burst stop is always legal and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Address bus and op-code |
| cmd_valid | output | 1 | Legal decoded command strobe |
| cmd_op | output | 4 | Decoded operation code (0 when no strobe) |
| cmd_bank | output | 2 | Bank of the command |
| cmd_row | output | 13 | Row given (activate) or recorded (read/write) |
| cmd_col | output | 9 | Column of a read or write |
| cmd_ap | output | 1 | Auto precharge requested on read or write |
| illegal | output | 1 | One-cycle flag for a command illegal in the current state |
| bank_open | output | 4 | Per-bank flag, high when active or closing |
| mode_op | output | 13 | Stored mode word |

## Verification
On every cycle the assertions check these rules. A suspended or deselected cycle never yields a strobe or an error. An all-bank precharge and a mode load are always followed by every bank reading idle. A read or write is only reported against an open bank. Inside each bank tracker, an activate opens the bank with the given row, a precharge closes it, and a closing bank stays frozen while the clock is suspended. The error-versus-accept decisions, the recall of a stored row on a later access, and the exact edge on which an auto-precharge bank returns to idle can only be shown by the bench's scenarios. These cover a burst length set through the mode word and a countdown stretched by a held-low clock enable.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_ACT    = 4'd1,
    OP_READ   = 4'd2,
    OP_WRITE  = 4'd3,
    OP_PRE    = 4'd4,
    OP_PREALL = 4'd5,
    OP_MRS    = 4'd6,
    OP_BST    = 4'd7,
    OP_AREF   = 4'd8,
    OP_SREF   = 4'd9
  } sdc_op_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_ACTIVE  = 2'd1,
    BK_CLOSING = 2'd2
  } sdc_bank_e;
endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
  import sdc_pkg::*;
(
  input  logic    en,
  input  logic    cke_now,
  input  logic    cs_n,
  input  logic    ras_n,
  input  logic    cas_n,
  input  logic    we_n,
  input  logic    a10,
  output sdc_op_e op
);
  // Pin pattern to operation; masked by chip select and a suspended clock.
  always_comb begin
    op = OP_NONE;
    if (en && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  op = OP_ACT;
        3'b010:  op = a10 ? OP_PREALL : OP_PRE;
        3'b101:  op = OP_READ;
        3'b100:  op = OP_WRITE;
        3'b000:  op = OP_MRS;
        3'b110:  op = OP_BST;
        3'b001:  op = cke_now ? OP_AREF : OP_SREF;
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sdc_bank.sv
module sdc_bank
  import sdc_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             act,
  input  logic             rdwr_ap,
  input  logic             pre,
  input  logic [ROW_W-1:0] row_in,
  input  logic [CNT_W-1:0] burst_len,
  output sdc_bank_e        state,
  output logic [ROW_W-1:0] row
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BK_IDLE;
      row   <= '0;
      cnt   <= '0;
    end else if (pre) begin
      state <= BK_IDLE;
      cnt   <= '0;
    end else if (act) begin
      state <= BK_ACTIVE;
      row   <= row_in;
    end else if (rdwr_ap) begin
      state <= BK_CLOSING;
      cnt   <= burst_len;
    end else if (state == BK_CLOSING && tick) begin
      if (cnt <= CNT_W'(1)) begin
        state <= BK_IDLE;
        cnt   <= '0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_ACT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> state == BK_IDLE); // R4
  AST_ACT_OPENS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> (state == BK_ACTIVE && row == $past(row_in))); // R4
  AST_AP_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rdwr_ap |-> state == BK_ACTIVE); // R9
  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    pre |=> state == BK_IDLE); // R6
  AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BK_CLOSING && !tick && !pre) |=> state == BK_CLOSING); // R10
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdc_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cke,
  input  logic                     cs_n,
  input  logic                     ras_n,
  input  logic                     cas_n,
  input  logic                     we_n,
  input  logic [$clog2(BANKS)-1:0] ba,
  input  logic [ADDR_W-1:0]        addr,
  output logic                     cmd_valid,
  output logic [3:0]               cmd_op,
  output logic [$clog2(BANKS)-1:0] cmd_bank,
  output logic [ROW_W-1:0]         cmd_row,
  output logic [COL_W-1:0]         cmd_col,
  output logic                     cmd_ap,
  output logic                     illegal,
  output logic [BANKS-1:0]         bank_open,
  output logic [ADDR_W-1:0]        mode_op
);
  localparam int BA_W  = $clog2(BANKS);
  localparam int COLS  = 1 << COL_W;
  localparam int CNT_W = $clog2(COLS + 1);

  function automatic logic [CNT_W-1:0] burst_of(input logic [2:0] code);
    case (code)
      3'd0:    return CNT_W'(1);
      3'd1:    return CNT_W'(2);
      3'd2:    return CNT_W'(4);
      3'd3:    return CNT_W'(8);
      default: return CNT_W'(COLS);
    endcase
  endfunction

  logic             cke_q;
  sdc_op_e          op;
  sdc_bank_e        st   [BANKS];
  logic [ROW_W-1:0] rows [BANKS];
  logic             all_idle, legal, accept, reject, is_rw;

  // Clock-enable history: the previous edge decides whether this one counts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  sdc_decode u_decode (
    .en(cke_q), .cke_now(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(addr[AP_BIT]), .op(op)
  );

  always_comb begin
    for (int i = 0; i < BANKS; i++) bank_open[i] = (st[i] != BK_IDLE);
  end
  assign all_idle = (bank_open == '0);
  assign is_rw    = (op == OP_READ) || (op == OP_WRITE);

  // Legality of the decoded command against the tracked bank state.
  always_comb begin
    case (op)
      OP_ACT:                  legal = (st[ba] == BK_IDLE);
      OP_READ, OP_WRITE:       legal = (st[ba] == BK_ACTIVE);
      OP_MRS, OP_AREF, OP_SREF: legal = all_idle;
      default:                 legal = 1'b1;
    endcase
  end
  assign accept = (op != OP_NONE) && legal;
  assign reject = (op != OP_NONE) && !legal;

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (ba == BA_W'(g));
    sdc_bank #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .tick(cke_q),
      .act(accept && op == OP_ACT && hit),
      .rdwr_ap(accept && is_rw && addr[AP_BIT] && hit),
      .pre(accept && (op == OP_PREALL || (op == OP_PRE && hit))),
      .row_in(addr[ROW_W-1:0]), .burst_len(burst_of(mode_op[2:0])),
      .state(st[g]), .row(rows[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NONE;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
      cmd_ap    <= 1'b0;
      illegal   <= 1'b0;
      mode_op   <= '0;
    end else begin
      cmd_valid <= accept;
      illegal   <= reject;
      cmd_op    <= accept ? op : OP_NONE;
      cmd_bank  <= ba;
      cmd_row   <= (op == OP_ACT) ? addr[ROW_W-1:0] : rows[ba];
      cmd_col   <= is_rw ? addr[COL_W-1:0] : '0;
      cmd_ap    <= accept && is_rw && addr[AP_BIT];
      if (accept && op == OP_MRS) mode_op <= addr;
    end
  end

  AST_DESELECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!cmd_valid && !illegal)); // R2
  AST_SUSPEND_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> (!cmd_valid && !illegal)); // R10
  AST_PREALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PREALL) |-> bank_open == '0); // R6
  AST_MRS_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_MRS) |-> bank_open == '0); // R7
  AST_RW_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_READ || cmd_op == OP_WRITE)) |-> bank_open[cmd_bank]); // R5
endmodule

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [12:0] addr = '0;
  logic cmd_valid, cmd_ap, illegal;
  logic [3:0] cmd_op, bank_open;
  logic [1:0] cmd_bank;
  logic [12:0] cmd_row, mode_op;
  logic [8:0] cmd_col;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  sdram_cmd_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
    .illegal(illegal), .bank_open(bank_open), .mode_op(mode_op)
  );

  // Pin patterns {cs_n,ras_n,cas_n,we_n}
  localparam logic [3:0] P_ACT = 4'b0011, P_PRE = 4'b0010, P_RD = 4'b0101,
    P_WR = 4'b0100, P_MRS = 4'b0000, P_BST = 4'b0110, P_REF = 4'b0001,
    P_NOP = 4'b0111, P_DES = 4'b1011;

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  pins;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic        ev;
    logic [3:0]  eop;
    logic        eill;
    logic [3:0]  eopen;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd4,  P_ACT, 2'd0, 13'h0123, 1'b1, 4'd1, 1'b0, 4'b0001}, // R4 open bank 0
    '{4'd5,  P_RD,  2'd0, 13'h0005, 1'b1, 4'd2, 1'b0, 4'b0001}, // R5 read active bank
    '{4'd8,  P_ACT, 2'd0, 13'h0040, 1'b0, 4'd0, 1'b1, 4'b0001}, // R8 activate active bank
    '{4'd5,  P_WR,  2'd2, 13'h0001, 1'b0, 4'd0, 1'b1, 4'b0001}, // R5 write idle bank
    '{4'd3,  P_ACT, 2'd2, 13'h0007, 1'b1, 4'd1, 1'b0, 4'b0101}, // R3 decode activate
    '{4'd7,  P_MRS, 2'd0, 13'h0002, 1'b0, 4'd0, 1'b1, 4'b0101}, // R7 mode load while open
    '{4'd11, P_REF, 2'd0, 13'h0000, 1'b0, 4'd0, 1'b1, 4'b0101}, // R11 refresh while open
    '{4'd6,  P_PRE, 2'd0, 13'h0000, 1'b1, 4'd4, 1'b0, 4'b0100}, // R6 single precharge
    '{4'd2,  P_DES, 2'd1, 13'h0000, 1'b0, 4'd0, 1'b0, 4'b0100}, // R2 deselect masked
    '{4'd3,  P_NOP, 2'd0, 13'h0000, 1'b0, 4'd0, 1'b0, 4'b0100}, // R3 no-operation
    '{4'd11, P_BST, 2'd0, 13'h0000, 1'b1, 4'd7, 1'b0, 4'b0100}, // R11 burst stop
    '{4'd6,  P_PRE, 2'd3, 13'h0400, 1'b1, 4'd5, 1'b0, 4'b0000}, // R6 precharge all
    '{4'd11, P_REF, 2'd0, 13'h0000, 1'b1, 4'd8, 1'b0, 4'b0000}, // R11 auto refresh
    '{4'd7,  P_MRS, 2'd0, 13'h0002, 1'b1, 4'd6, 1'b0, 4'b0000}  // R7 burst length 4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] pins, input logic [1:0] b,
                      input logic [12:0] a, input logic ck);
    {cs_n, ras_n, cas_n, we_n} = pins;
    ba = b; addr = a; cke = ck;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 open", {28'd0, bank_open}, 32'd0);
    check("R1 valid", {31'd0, cmd_valid}, 32'd0);
    check("R1 illegal", {31'd0, illegal}, 32'd0);
    check("R1 mode", {19'd0, mode_op}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      step(VECS[i].pins, VECS[i].ba, VECS[i].addr, 1'b1);
      check({tag, " valid"}, {31'd0, cmd_valid}, {31'd0, VECS[i].ev});
      check({tag, " op"}, {28'd0, cmd_op}, {28'd0, VECS[i].eop});
      check({tag, " illegal"}, {31'd0, illegal}, {31'd0, VECS[i].eill});
      check({tag, " open"}, {28'd0, bank_open}, {28'd0, VECS[i].eopen});
    end
    check("R7 mode stored", {19'd0, mode_op}, 32'h2);

    // R4 row recall on later access, R5 column and bank
    step(P_ACT, 2'd1, 13'h1ABC, 1'b1);
    step(P_RD, 2'd1, 13'h001F, 1'b1);
    check("R4 recalled row", {19'd0, cmd_row}, 32'h1ABC);
    check("R5 column", {23'd0, cmd_col}, 32'h1F);
    check("R5 bank", {30'd0, cmd_bank}, 32'd1);
    check("R5 no ap", {31'd0, cmd_ap}, 32'd0);

    // R9 auto precharge with burst length 4 on bank 3
    step(P_ACT, 2'd3, 13'h0009, 1'b1);
    step(P_RD, 2'd3, 13'h0403, 1'b1);
    check("R9 ap flag", {31'd0, cmd_ap}, 32'd1);
    check("R9 closing open", {31'd0, bank_open[3]}, 32'd1);
    step(P_WR, 2'd3, 13'h0003, 1'b1);
    check("R9 write to closing", {31'd0, illegal}, 32'd1);
    step(P_NOP, 2'd0, 13'h0, 1'b1);
    check("R9 open edge2", {31'd0, bank_open[3]}, 32'd1);
    step(P_NOP, 2'd0, 13'h0, 1'b1);
    check("R9 open edge3", {31'd0, bank_open[3]}, 32'd1);
    step(P_NOP, 2'd0, 13'h0, 1'b1);
    check("R9 idle edge4", {31'd0, bank_open[3]}, 32'd0);

    // R10 suspended clock: countdown frozen, command ignored
    step(P_RD, 2'd1, 13'h0400, 1'b1);
    for (int k = 0; k < 5; k++) step(P_NOP, 2'd0, 13'h0, 1'b0);
    check("R10 frozen open", {31'd0, bank_open[1]}, 32'd1);
    step(P_ACT, 2'd0, 13'h0055, 1'b1);
    check("R10 ignored valid", {31'd0, cmd_valid}, 32'd0);
    check("R10 ignored illegal", {31'd0, illegal}, 32'd0);
    check("R10 ignored bank0", {31'd0, bank_open[0]}, 32'd0);
    step(P_NOP, 2'd0, 13'h0, 1'b1);
    step(P_NOP, 2'd0, 13'h0, 1'b1);
    check("R10 still open", {31'd0, bank_open[1]}, 32'd1);
    step(P_NOP, 2'd0, 13'h0, 1'b1);
    check("R10 closed after resume", {31'd0, bank_open[1]}, 32'd0);

    // R11 self refresh when cke low in the sampling cycle
    step(P_REF, 2'd0, 13'h0, 1'b0);
    check("R11 self refresh valid", {31'd0, cmd_valid}, 32'd1);
    check("R11 self refresh op", {28'd0, cmd_op}, 32'd9);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule